// File: doc/BRIEF.md
# Segmented Instruction Prefetch Unit

This block keeps a short first-in, first-out queue of instruction bytes topped up ahead of the execution side of a processor whose memory is addressed through segments. It holds a 16-bit code-segment value and a 16-bit fetch offset. From these it forms a 20-bit physical read address: the segment is moved four bit positions up and the offset is added to it. Reads go out on a plain request/acknowledge port, and each returned byte is appended to a six-entry queue.

The consumer takes bytes one per cycle through a valid/ready pop port. It also sees the offset of the byte at the head of the queue, so it can follow the architectural instruction pointer. Fetching runs on its own whenever the queue has room, so memory reads overlap with consumption. A redirect input, used for branches, loads a new segment and offset, empties the queue in one cycle and withdraws the current request.

Top module: `seg_prefetch_unit`

## Requirements
- R1: The queue never holds more than 6 bytes; `mem_req` is low whenever 6 bytes are held and high whenever fewer are held and no redirect is being applied.
- R2: Bytes appear on `pop_data` in exactly the order their reads were acknowledged.
- R3: `mem_addr` equals (segment × 16 + fetch offset) modulo 2^20.
- R4: The fetch offset grows by one for every acknowledged read and wraps from 16'hFFFF to 16'h0000 without changing the segment.
- R5: While `mem_req` is high and `mem_ack` is low and no redirect is applied, the following cycle still has `mem_req` high with an unchanged `mem_addr`.
- R6: A cycle with `redir_valid` high empties the queue and loads `redir_seg`/`redir_off`; in the next cycle `head_off` equals the loaded offset and fetching proceeds from the new address.
- R7: During a redirect cycle `mem_req` is low, so an acknowledge in that cycle stores no byte, and a pop in that cycle has no effect; `pop_valid` is low in the cycle after a redirect.
- R8: `pop_valid` is high exactly when the queue is non-empty; asserting `pop_ready` on an empty queue changes neither the queue nor `head_off`.
- R9: `head_off` equals the fetch offset minus the number of queued bytes, modulo 2^16, i.e. the offset of the byte at the head.
- R10: After reset the queue is empty and the first request reads from segment `RESET_SEG` (default 16'hFFFF) at offset `RESET_OFF` (default 16'h0000), giving address 20'hFFFF0.
- R11: An acknowledged read and a pop in the same cycle both take effect: the occupancy stays the same and no byte is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| redir_valid | input | 1 | Load a new fetch stream and flush the queue |
| redir_seg | input | 16 | Code-segment value for the redirect |
| redir_off | input | 16 | Starting offset for the redirect |
| mem_req | output | 1 | Read request for one instruction byte |
| mem_addr | output | 20 | Physical address of the requested byte |
| mem_ack | input | 1 | Memory accepts the request and returns the byte in this cycle |
| mem_rdata | input | 8 | Byte returned with `mem_ack` |
| pop_valid | output | 1 | A byte is available at the queue head |
| pop_data | output | 8 | Byte at the queue head |
| pop_ready | input | 1 | Consumer takes the head byte in this cycle |
| head_off | output | 16 | Offset of the byte at the queue head |

## Verification
The acknowledge of a fetched byte can fall in the same cycle as the consumer's pop, and either can also coincide with a redirect. The bench provokes these collisions with random acknowledge, pop and redirect patterns from a seeded generator. It also uses directed cycles that put all three into one cycle on a full queue. A bench-side model of the queue, the offset and the address arithmetic judges each cycle's `mem_req`, `mem_addr`, `pop_valid`, `pop_data` and `head_off` against what the collision must produce.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

   localparam int unsigned PFQ_SEG_SHIFT = 4;

   // true when n is a power of two (n > 0)
   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

   // index width for a storage of n entries (at least one bit)
   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/pfq_addr_gen.sv
module pfq_addr_gen #(
   parameter int unsigned SEG_W   = 16,
   parameter int unsigned OFF_W   = 16,
   parameter int unsigned SHIFT   = pfq_pkg::PFQ_SEG_SHIFT,
   parameter int unsigned PADDR_W = 20
) (
   input  logic [SEG_W-1:0]   seg,
   input  logic [OFF_W-1:0]   off,
   output logic [PADDR_W-1:0] paddr
);
   localparam int unsigned SEG_SPAN = SEG_W + SHIFT;
   localparam int unsigned SUM_W    = ((SEG_SPAN > OFF_W) ? SEG_SPAN : OFF_W) + 1;

   logic [SUM_W-1:0] sum;

   assign sum = (SUM_W'(seg) << SHIFT) + SUM_W'(off);

   generate
      if (PADDR_W <= SUM_W) begin : g_trunc
         assign paddr = sum[PADDR_W-1:0];
      end else begin : g_extend
         assign paddr = PADDR_W'(sum);
      end
   endgenerate

endmodule

// File: rtl/pfq_byte_fifo.sv
module pfq_byte_fifo #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 6,
   localparam int unsigned PTR_W = pfq_pkg::idx_width(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  count,
   output logic              empty,
   output logic              full
);
   logic [DATA_W-1:0] store [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_ptr_nx, rd_ptr_nx;

   generate
      if (pfq_pkg::is_pow2(DEPTH)) begin : g_pow2_wrap
         assign wr_ptr_nx = wr_ptr + 1'b1;
         assign rd_ptr_nx = rd_ptr + 1'b1;
      end else begin : g_cmp_wrap
         assign wr_ptr_nx = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_ptr_nx = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign rd_data = store[rd_ptr];

   always_ff @(posedge clk) begin
      if (wr_en && !flush) begin
         store[wr_ptr] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (wr_en) wr_ptr <= wr_ptr_nx;
         if (rd_en) rd_ptr <= rd_ptr_nx;
         case ({wr_en, rd_en})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !wr_en || rd_en); // R1
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !rd_en); // R8
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty); // R6

endmodule

// File: rtl/pfq_fetch_ctl.sv
module pfq_fetch_ctl #(
   parameter int unsigned      SEG_W     = 16,
   parameter int unsigned      OFF_W     = 16,
   parameter logic [SEG_W-1:0] RESET_SEG = '1,
   parameter logic [OFF_W-1:0] RESET_OFF = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             redir_valid,
   input  logic [SEG_W-1:0] redir_seg,
   input  logic [OFF_W-1:0] redir_off,
   input  logic             queue_full,
   input  logic             mem_ack,
   output logic             mem_req,
   output logic             accept,
   output logic [SEG_W-1:0] seg_q,
   output logic [OFF_W-1:0] off_q
);
   assign mem_req = !queue_full && !redir_valid;
   assign accept  = mem_req && mem_ack;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seg_q <= RESET_SEG;
         off_q <= RESET_OFF;
      end else if (redir_valid) begin
         seg_q <= redir_seg;
         off_q <= redir_off;
      end else if (accept) begin
         off_q <= off_q + 1'b1;
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack && !redir_valid) |=> (mem_req || redir_valid) && $stable(off_q) && $stable(seg_q)); // R5
   AST_OFF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !redir_valid) |=> off_q == OFF_W'($past(off_q) + 1'b1)); // R4
   AST_REDIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |=> (seg_q == $past(redir_seg)) && (off_q == $past(redir_off))); // R6

endmodule

// File: rtl/seg_prefetch_unit.sv
module seg_prefetch_unit #(
   parameter int unsigned      SEG_W     = 16,
   parameter int unsigned      OFF_W     = 16,
   parameter int unsigned      PADDR_W   = 20,
   parameter int unsigned      DATA_W    = 8,
   parameter int unsigned      DEPTH     = 6,
   parameter logic [SEG_W-1:0] RESET_SEG = 16'hFFFF,
   parameter logic [OFF_W-1:0] RESET_OFF = 16'h0000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               redir_valid,
   input  logic [SEG_W-1:0]   redir_seg,
   input  logic [OFF_W-1:0]   redir_off,
   output logic               mem_req,
   output logic [PADDR_W-1:0] mem_addr,
   input  logic               mem_ack,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic               pop_valid,
   output logic [DATA_W-1:0]  pop_data,
   input  logic               pop_ready,
   output logic [OFF_W-1:0]   head_off
);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("seg_prefetch_unit: DEPTH must be at least 2");
      end
      if (CNT_W > OFF_W) begin : g_bad_off
         $error("seg_prefetch_unit: DEPTH too large for OFF_W");
      end
      if (PADDR_W < OFF_W) begin : g_bad_paddr
         $error("seg_prefetch_unit: PADDR_W narrower than OFF_W");
      end
   endgenerate

   logic             q_full, q_empty, accept, pop_fire;
   logic [CNT_W-1:0] q_count;
   logic [SEG_W-1:0] seg_q;
   logic [OFF_W-1:0] off_q;

   pfq_fetch_ctl #(
      .SEG_W    (SEG_W),
      .OFF_W    (OFF_W),
      .RESET_SEG(RESET_SEG),
      .RESET_OFF(RESET_OFF)
   ) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .redir_valid(redir_valid),
      .redir_seg  (redir_seg),
      .redir_off  (redir_off),
      .queue_full (q_full),
      .mem_ack    (mem_ack),
      .mem_req    (mem_req),
      .accept     (accept),
      .seg_q      (seg_q),
      .off_q      (off_q)
   );

   pfq_addr_gen #(
      .SEG_W  (SEG_W),
      .OFF_W  (OFF_W),
      .SHIFT  (pfq_pkg::PFQ_SEG_SHIFT),
      .PADDR_W(PADDR_W)
   ) u_agen (
      .seg  (seg_q),
      .off  (off_q),
      .paddr(mem_addr)
   );

   assign pop_valid = !q_empty;
   assign pop_fire  = pop_valid && pop_ready && !redir_valid;

   pfq_byte_fifo #(
      .DATA_W(DATA_W),
      .DEPTH (DEPTH)
   ) u_queue (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (redir_valid),
      .wr_en  (accept),
      .wr_data(mem_rdata),
      .rd_en  (pop_fire),
      .rd_data(pop_data),
      .count  (q_count),
      .empty  (q_empty),
      .full   (q_full)
   );

   assign head_off = off_q - OFF_W'(q_count);

   AST_HEAD_AFTER_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |=> head_off == $past(redir_off)); // R6
   AST_DROP_ON_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |=> !pop_valid); // R7
   AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!pop_valid && !mem_ack && !redir_valid) |=> $stable(head_off) && !pop_valid); // R8
   AST_FULL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (q_count == CNT_W'(DEPTH)) |-> !mem_req); // R1

endmodule

// File: tb/seg_prefetch_unit_test.sv
`timescale 1ns/1ps
module seg_prefetch_unit_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        redir_valid;
   logic [15:0] redir_seg, redir_off;
   logic        mem_req, mem_ack, pop_valid, pop_ready;
   logic [19:0] mem_addr;
   logic [7:0]  mem_rdata, pop_data;
   logic [15:0] head_off;

   int unsigned checks = 0;
   int unsigned errors = 0;
   bit          done   = 1'b0;

   // bench model
   logic [7:0]  mq[$];
   logic [15:0] m_seg, m_off;
   bit          prev_redir = 1'b0, prev_hold = 1'b0, prev_both = 1'b0, prev_wrap = 1'b0;
   logic [19:0] prev_addr;

   always #2.5 clk = ~clk;

   function automatic logic [7:0] memfn(input logic [19:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ {4'h0, a[19:16]} ^ 8'h5A;
   endfunction

   function automatic logic [19:0] paddr(input logic [15:0] s, input logic [15:0] o);
      logic [20:0] t;
      t = ({5'b0, s} << 4) + {5'b0, o};
      return t[19:0];
   endfunction

   assign mem_rdata = memfn(mem_addr);

   seg_prefetch_unit uut (
      .clk(clk), .rst_n(rst_n),
      .redir_valid(redir_valid), .redir_seg(redir_seg), .redir_off(redir_off),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .pop_valid(pop_valid), .pop_data(pop_data), .pop_ready(pop_ready),
      .head_off(head_off)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // one cycle: drive at negedge, check settled outputs, advance model
   task automatic cycle(input bit rd, input logic [15:0] rs, input logic [15:0] ro,
                        input bit ack, input bit rdy);
      bit exp_req, exp_pv, acc, popd;
      @(negedge clk);
      redir_valid = rd; redir_seg = rs; redir_off = ro;
      mem_ack = ack; pop_ready = rdy;
      #1;
      exp_req = (mq.size() < 6) && !rd;
      exp_pv  = (mq.size() != 0);
      check("R1 mem_req vs occupancy", {31'b0, mem_req}, {31'b0, exp_req});
      check("R8 pop_valid", {31'b0, pop_valid}, {31'b0, exp_pv});
      if (prev_redir) check("R7 pop_valid after redirect", {31'b0, pop_valid}, 32'h0);
      if (prev_redir) check("R6 head_off after redirect", {16'b0, head_off}, {16'b0, m_off});
      if (prev_both)  check("R11 head_off after ack+pop", {16'b0, head_off},
                            {16'b0, 16'(m_off - 16'(mq.size()))});
      else            check("R9 head_off", {16'b0, head_off}, {16'b0, 16'(m_off - 16'(mq.size()))});
      if (exp_req) begin
         if (prev_wrap)      check("R4 address after offset wrap", {12'b0, mem_addr}, {12'b0, paddr(m_seg, m_off)});
         else if (prev_redir) check("R6 address after redirect", {12'b0, mem_addr}, {12'b0, paddr(m_seg, m_off)});
         else                check("R3 fetch address", {12'b0, mem_addr}, {12'b0, paddr(m_seg, m_off)});
         if (prev_hold)      check("R5 held address", {12'b0, mem_addr}, {12'b0, prev_addr});
      end
      if (exp_pv) check("R2 pop_data order", {24'b0, pop_data}, {24'b0, mq[0]});
      acc  = exp_req && ack;
      popd = exp_pv && rdy && !rd;
      prev_hold  = exp_req && !ack && !rd;
      prev_addr  = paddr(m_seg, m_off);
      prev_redir = rd;
      prev_both  = acc && popd;
      prev_wrap  = acc && (m_off == 16'hFFFF);
      if (rd) begin
         mq.delete();
         m_seg = rs; m_off = ro;
      end else begin
         if (popd) void'(mq.pop_front());
         if (acc) begin
            mq.push_back(memfn(paddr(m_seg, m_off)));
            m_off = m_off + 16'd1;
         end
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = 32'd1234;
      void'($urandom(seed));
      rst_n = 1'b0; redir_valid = 1'b0; redir_seg = '0; redir_off = '0;
      mem_ack = 1'b0; pop_ready = 1'b0;
      m_seg = 16'hFFFF; m_off = 16'h0000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R10 reset state
      check("R10 pop_valid after reset", {31'b0, pop_valid}, 32'h0);
      check("R10 mem_req after reset", {31'b0, mem_req}, 32'h1);
      check("R10 reset address", {12'b0, mem_addr}, 32'h000FFFF0);
      check("R10 head_off after reset", {16'b0, head_off}, 32'h0);

      // R1: fill with no pops, queue must stop at 6
      for (int i = 0; i < 10; i++) cycle(1'b0, '0, '0, 1'b1, 1'b0);
      // R11: ack and pop together on a queue below full
      cycle(1'b0, '0, '0, 1'b0, 1'b1);
      for (int i = 0; i < 6; i++) cycle(1'b0, '0, '0, 1'b1, 1'b1);
      // R7: redirect with ack and pop on a full queue
      for (int i = 0; i < 4; i++) cycle(1'b0, '0, '0, 1'b1, 1'b0);
      cycle(1'b1, 16'h1234, 16'h0100, 1'b1, 1'b1);
      // R8: pop on empty queue with no ack
      for (int i = 0; i < 4; i++) cycle(1'b0, '0, '0, 1'b0, 1'b1);
      // R4/R3: segment and offset wraps
      cycle(1'b1, 16'hFFFF, 16'hFFFE, 1'b0, 1'b0);
      for (int i = 0; i < 5; i++) cycle(1'b0, '0, '0, 1'b1, 1'b0);
      for (int i = 0; i < 8; i++) cycle(1'b0, '0, '0, 1'b0, 1'b1);
      // R5: request waits for ack
      for (int i = 0; i < 4; i++) cycle(1'b0, '0, '0, 1'b0, 1'b0);

      // seeded random mix
      for (int i = 0; i < 4000; i++) begin
         bit rd, ak, rdy;
         rd  = ($urandom % 40) == 0;
         ak  = ($urandom % 5) < 3;
         rdy = ($urandom % 2) == 1;
         cycle(rd, 16'($urandom), 16'($urandom), ak, rdy);
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule